// File: doc/BRIEF.md
# Serial Sensor Register Interface

This block is the serial slave front end of a temperature-sensing device. A host reaches a bank of eight registers over a four-wire serial link (serial clock, chip select, data in, data out). Each transaction opens with one command byte that carries a read/write flag and a 3-bit register address. A data phase follows, and its length is either 8 or 16 bits, chosen by the addressed register. Setup registers (limits, hysteresis, configuration) can be read and written. Measurement and status values come from input ports and can only be read. An identification byte is fixed by a parameter.

The serial pins are sampled by the block's system clock. Bits are taken on rising serial-clock edges and driven on falling edges, which is SPI mode 3 with the clock idling high. The host may tie chip select low and frame transactions by bit count alone. A run of 32 ones on the data input brings a lost interface back to a known state. The writable registers are presented on output ports so the rest of the chip can use them.

Top module: `spi_sense_regs`

## Requirements
- R1: A command byte is 8 bits, MSB first. It is well formed when bit 7 is 0 and bits 2..0 are 0. Bit 6 set to 1 means read and 0 means write. Bits 5..3 are the register address.
- R2: Addresses 2, 4, 5 and 6 have a 16-bit data phase. Addresses 0, 1, 3 and 7 have an 8-bit data phase. Each data phase is sent MSB first.
- R3: In a well-formed read, the output enable is high and the first data bit is on the data output from the first falling serial-clock edge after the command byte. Each later falling edge presents the next bit. The output enable is low during a command byte and while chip select is high.
- R4: A write to address 1 (configuration, 8 bits), 4, 5, 6 (limits, 16 bits) or 7 (hysteresis, 8 bits) updates that register once the last data bit has been received. The new value appears on its output port and on readback.
- R5: Writes to address 0 (status input), 2 (measurement input) and 3 (identification, 0xC3) are discarded. Readback of these addresses still returns the input or the constant.
- R6: Chip select going high aborts a transaction. A partly received write changes nothing, and the next frame starts with a command byte.
- R7: With chip select held low, transactions follow each other back to back, framed by the bit count only.
- R8: A malformed command byte (bit 7 set or bits 2..0 nonzero) is followed by an 8-bit data phase. That phase writes nothing and never enables the data output.
- R9: The 32nd consecutive 1 received on the data input restores every writable register to its power-on value. The following bit is taken as the start of a command byte.
- R10: A received 0 clears the count of consecutive ones, and so does chip select going high. Inside a frame the count runs across command and data boundaries.
- R11: After reset the registers hold configuration 0x00, high limit 0x2000, low limit 0x0500, critical limit 0x4980 and hysteresis 0x05, and the output enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, idles high |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for the data output driver |
| status_i | input | 8 | Status byte returned at address 0 |
| temp_i | input | 16 | Measurement word returned at address 2 |
| cfg_o | output | 8 | Configuration register |
| lim_high_o | output | 16 | High limit register |
| lim_low_o | output | 16 | Low limit register |
| lim_crit_o | output | 16 | Critical limit register |
| hyst_o | output | 8 | Hysteresis register |

## Verification
Every serial edge passes through two synchronizer flops and an edge register. The data output and its enable therefore settle three system clocks after the falling serial edge that moves them. The bench holds each serial level for eight system clocks and samples the data output and the enable just before it raises the serial clock, five clocks after they settle. A register write lands three clocks after the final rising edge. The register outputs are compared only after chip select has been high for 32 clocks. Readback through a later frame confirms the same values at the block's serial pins.

// File: rtl/spi_sense_regs.sv
module spi_sense_regs #(
  parameter int          SYNC_STAGES = 2,
  parameter int          RESET_ONES  = 32,
  parameter logic [7:0]  ID_VALUE    = 8'hC3,
  parameter logic [7:0]  CFG_INIT    = 8'h00,
  parameter logic [15:0] HIGH_INIT   = 16'h2000,
  parameter logic [15:0] LOW_INIT    = 16'h0500,
  parameter logic [15:0] CRIT_INIT   = 16'h4980,
  parameter logic [7:0]  HYST_INIT   = 8'h05
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclk,
  input  logic        cs_n,
  input  logic        mosi,
  output logic        miso,
  output logic        miso_oe,
  input  logic [7:0]  status_i,
  input  logic [15:0] temp_i,
  output logic [7:0]  cfg_o,
  output logic [15:0] lim_high_o,
  output logic [15:0] lim_low_o,
  output logic [15:0] lim_crit_o,
  output logic [7:0]  hyst_o
);
  localparam int          OW        = $clog2(RESET_ONES + 1);
  localparam logic [OW-1:0] ONES_LAST = OW'(RESET_ONES - 1);

  logic [SYNC_STAGES-1:0] sclk_sh, cs_sh, mosi_sh;
  logic sclk_s, cs_s, mosi_s, sclk_d;
  logic rise_evt, fall_evt;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sclk_sh <= '1;
      cs_sh   <= '1;
      mosi_sh <= '0;
      sclk_d  <= 1'b1;
    end else begin
      sclk_sh <= {sclk_sh[SYNC_STAGES-2:0], sclk};
      cs_sh   <= {cs_sh[SYNC_STAGES-2:0], cs_n};
      mosi_sh <= {mosi_sh[SYNC_STAGES-2:0], mosi};
      sclk_d  <= sclk_s;
    end

  assign sclk_s   = sclk_sh[SYNC_STAGES-1];
  assign cs_s     = cs_sh[SYNC_STAGES-1];
  assign mosi_s   = mosi_sh[SYNC_STAGES-1];
  assign rise_evt = ~cs_s & sclk_s & ~sclk_d;
  assign fall_evt = ~cs_s & ~sclk_s & sclk_d;

  function automatic logic is_wide(input logic [2:0] a);
    return (a == 3'd2) || (a == 3'd4) || (a == 3'd5) || (a == 3'd6);
  endfunction

  function automatic logic is_writable(input logic [2:0] a);
    return (a == 3'd1) || (a >= 3'd4);
  endfunction

  logic          in_data, rd_act, wr_act, wide_q, first_fall, oe_q;
  logic [2:0]    addr_q;
  logic [6:0]    cmd_sr;
  logic [4:0]    bcnt;
  logic [15:0]   rx_sr, tx_sr;
  logic [OW-1:0] ones;

  logic [7:0]  cmd_byte;
  logic [2:0]  cmd_addr;
  logic        cmd_ok, srst, data_done, wr_fire;
  logic [4:0]  last_bit;
  logic [15:0] wdata, rd_word;

  assign cmd_byte  = {cmd_sr, mosi_s};
  assign cmd_addr  = cmd_byte[5:3];
  assign cmd_ok    = ~cmd_byte[7] & (cmd_byte[2:0] == 3'd0);
  assign srst      = rise_evt & mosi_s & (ones == ONES_LAST);
  assign last_bit  = wide_q ? 5'd15 : 5'd7;
  assign data_done = rise_evt & ~srst & in_data & (bcnt == last_bit);
  assign wdata     = {rx_sr[14:0], mosi_s};
  assign wr_fire   = data_done & wr_act;

  always_comb
    case (cmd_addr)
      3'd0:    rd_word = {status_i, 8'h00};
      3'd1:    rd_word = {cfg_o, 8'h00};
      3'd2:    rd_word = temp_i;
      3'd3:    rd_word = {ID_VALUE, 8'h00};
      3'd4:    rd_word = lim_high_o;
      3'd5:    rd_word = lim_low_o;
      3'd6:    rd_word = lim_crit_o;
      default: rd_word = {hyst_o, 8'h00};
    endcase

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      in_data    <= 1'b0;
      rd_act     <= 1'b0;
      wr_act     <= 1'b0;
      wide_q     <= 1'b0;
      first_fall <= 1'b0;
      oe_q       <= 1'b0;
      addr_q     <= '0;
      cmd_sr     <= '0;
      bcnt       <= '0;
      rx_sr      <= '0;
      tx_sr      <= '0;
      ones       <= '0;
    end else if (cs_s || srst) begin
      in_data    <= 1'b0;
      rd_act     <= 1'b0;
      wr_act     <= 1'b0;
      first_fall <= 1'b0;
      oe_q       <= 1'b0;
      bcnt       <= '0;
      ones       <= '0;
    end else if (rise_evt) begin
      ones <= mosi_s ? ones + 1'b1 : '0;
      if (!in_data) begin
        cmd_sr <= cmd_byte[6:0];
        bcnt   <= bcnt + 1'b1;
        if (bcnt == 5'd7) begin
          bcnt       <= '0;
          in_data    <= 1'b1;
          addr_q     <= cmd_addr;
          wide_q     <= cmd_ok & is_wide(cmd_addr);
          rd_act     <= cmd_ok & cmd_byte[6];
          wr_act     <= cmd_ok & ~cmd_byte[6] & is_writable(cmd_addr);
          tx_sr      <= rd_word;
          first_fall <= 1'b1;
        end
      end else begin
        rx_sr <= wdata;
        bcnt  <= bcnt + 1'b1;
        if (bcnt == last_bit) begin
          bcnt    <= '0;
          in_data <= 1'b0;
          rd_act  <= 1'b0;
          wr_act  <= 1'b0;
        end
      end
    end else if (fall_evt) begin
      if (in_data && rd_act) begin
        if (first_fall) begin
          oe_q       <= 1'b1;
          first_fall <= 1'b0;
        end else begin
          tx_sr <= {tx_sr[14:0], 1'b0};
        end
      end else begin
        oe_q <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cfg_o      <= CFG_INIT;
      lim_high_o <= HIGH_INIT;
      lim_low_o  <= LOW_INIT;
      lim_crit_o <= CRIT_INIT;
      hyst_o     <= HYST_INIT;
    end else if (srst) begin
      cfg_o      <= CFG_INIT;
      lim_high_o <= HIGH_INIT;
      lim_low_o  <= LOW_INIT;
      lim_crit_o <= CRIT_INIT;
      hyst_o     <= HYST_INIT;
    end else if (wr_fire) begin
      case (addr_q)
        3'd1:    cfg_o      <= wdata[7:0];
        3'd4:    lim_high_o <= wdata;
        3'd5:    lim_low_o  <= wdata;
        3'd6:    lim_crit_o <= wdata;
        3'd7:    hyst_o     <= wdata[7:0];
        default: ;
      endcase
    end

  assign miso    = tx_sr[15];
  assign miso_oe = oe_q;
endmodule

// File: rtl/spi_sense_regs_chk.sv
module spi_sense_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        miso,
  input logic        miso_oe,
  input logic        rise_evt,
  input logic        fall_evt,
  input logic        in_data,
  input logic [4:0]  bcnt,
  input logic [7:0]  cfg_o,
  input logic [15:0] lim_high_o
);
  AST_OE_OFF_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso_oe); // R3
  AST_OE_RISES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(miso_oe) |-> $past(fall_evt)); // R3
  AST_MISO_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (miso_oe && $past(miso_oe) && !$stable(miso)) |-> $past(fall_evt)); // R3
  AST_NO_OE_IN_COMMAND: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fall_evt) && !$past(in_data)) |-> !miso_oe); // R3
  AST_CMD_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_data |-> (bcnt < 5'd8)); // R1
  AST_DATA_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    in_data |-> (bcnt < 5'd16)); // R2
  AST_CFG_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg_o) |-> $past(rise_evt)); // R4
  AST_HIGH_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lim_high_o) |-> $past(rise_evt)); // R4
endmodule

bind spi_sense_regs spi_sense_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .miso(miso), .miso_oe(miso_oe),
  .rise_evt(rise_evt), .fall_evt(fall_evt), .in_data(in_data), .bcnt(bcnt),
  .cfg_o(cfg_o), .lim_high_o(lim_high_o)
);

// File: tb/spi_sense_regs_test.sv
module spi_sense_regs_test;
  localparam int HALF = 8;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n, sclk, cs_n, mosi;
  logic miso, miso_oe;
  logic [7:0]  status_in, cfg_o, hyst_o;
  logic [15:0] temp_in, lim_high_o, lim_low_o, lim_crit_o;

  int tests = 0, failed = 0, cyc = 0;
  logic [15:0] mdl [8];

  always #2 clk = ~clk;

  spi_sense_regs uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .status_i(status_in), .temp_i(temp_in),
    .cfg_o(cfg_o), .lim_high_o(lim_high_o), .lim_low_o(lim_low_o),
    .lim_crit_o(lim_crit_o), .hyst_o(hyst_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG) begin
      failed = failed + 1;
      $display("FAIL watchdog (all requirements): got %0d cycles expected < %0d", cyc, WATCHDOG);
      $display("[TB] %0d tests run, %0d failed", tests + 1, failed);
      $finish;
    end
  end

  function automatic bit f_wide(input logic [2:0] a);
    return a == 2 || a == 4 || a == 5 || a == 6;
  endfunction
  function automatic bit f_writable(input logic [2:0] a);
    return a == 1 || a >= 4;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) mdl[i] = 16'h0;
    mdl[1] = 16'h0000; mdl[4] = 16'h2000; mdl[5] = 16'h0500;
    mdl[6] = 16'h4980; mdl[7] = 16'h0005;
  endtask

  function automatic logic [15:0] exp_read(input logic [2:0] a);
    case (a)
      3'd0:    return {8'h00, status_in};
      3'd2:    return temp_in;
      3'd3:    return 16'h00C3;
      default: return mdl[a];
    endcase
  endfunction

  task automatic check(input string req, input string what, input logic [15:0] got, input logic [15:0] exp);
    tests++;
    if (got !== exp) begin
      failed++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic check_outputs(input string req);
    check(req, "cfg_o", {8'h00, cfg_o}, mdl[1]);
    check(req, "lim_high_o", lim_high_o, mdl[4]);
    check(req, "lim_low_o", lim_low_o, mdl[5]);
    check(req, "lim_crit_o", lim_crit_o, mdl[6]);
    check(req, "hyst_o", {8'h00, hyst_o}, mdl[7]);
  endtask

  task automatic send_bit(input logic b, output logic r, output logic oe);
    sclk = 1'b0; mosi = b;
    repeat (HALF) @(negedge clk);
    r = miso; oe = miso_oe;
    sclk = 1'b1;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_begin();
    if (cs_n) begin
      cs_n = 1'b0;
      repeat (HALF) @(negedge clk);
    end
  endtask

  task automatic cs_end();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (4 * HALF) @(negedge clk);
  endtask

  task automatic send_run(input int n, input logic b);
    logic r, oe;
    for (int i = 0; i < n; i++) send_bit(b, r, oe);
  endtask

  task automatic xfer(input logic [7:0] cmd, input logic [15:0] wd, input bit keep,
                      output logic [15:0] rd, output int bad_c, output int bad_d);
    logic r, oe, exp_oe;
    bit ok;
    int n;
    ok = !cmd[7] && cmd[2:0] == 3'd0;
    n = (ok && f_wide(cmd[5:3])) ? 16 : 8;
    exp_oe = ok && cmd[6];
    rd = '0; bad_c = 0; bad_d = 0;
    cs_begin();
    for (int i = 7; i >= 0; i--) begin
      send_bit(cmd[i], r, oe);
      if (oe !== 1'b0) bad_c++;
    end
    for (int i = n - 1; i >= 0; i--) begin
      send_bit(wd[i], r, oe);
      rd = {rd[14:0], r};
      if (oe !== exp_oe) bad_d++;
    end
    if (!keep) cs_end();
  endtask

  function automatic logic [7:0] rcmd(input logic [2:0] a);
    return {2'b01, a, 3'b000};
  endfunction
  function automatic logic [7:0] wcmd(input logic [2:0] a);
    return {2'b00, a, 3'b000};
  endfunction

  task automatic do_write(input logic [2:0] a, input logic [15:0] d, input bit keep);
    logic [15:0] rd; int bc, bd;
    xfer(wcmd(a), d, keep, rd, bc, bd);
    if (f_writable(a)) mdl[a] = f_wide(a) ? d : {8'h00, d[7:0]};
    check("R3", "oe during write", 16'(bc + bd), 16'd0);
  endtask

  task automatic do_read(input string req, input logic [2:0] a, input bit keep);
    logic [15:0] rd; int bc, bd;
    xfer(rcmd(a), 16'h0, keep, rd, bc, bd);
    check(req, $sformatf("read addr %0d", a), rd, exp_read(a));
    check("R3", "oe low in command", 16'(bc), 16'd0);
    check("R3", "oe high in read data", 16'(bd), 16'd0);
  endtask

  initial begin
    logic [15:0] rd;
    int bc, bd;
    logic r, oe;
    sclk = 1'b1; cs_n = 1'b1; mosi = 1'b0; rst_n = 1'b0;
    status_in = 8'h5A; temp_in = 16'h1234;
    model_reset();
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);

    check_outputs("R11");
    check("R11", "miso_oe after reset", {15'h0, miso_oe}, 16'h0);

    for (int a = 0; a < 8; a++) do_read(f_wide(3'(a)) ? "R2" : "R1", 3'(a), 1'b0);

    for (int k = 0; k < 40; k++) begin
      logic [2:0] a;
      logic [15:0] d;
      a = 3'($urandom % 8);
      d = 16'($urandom);
      status_in = 8'($urandom);
      temp_in = 16'($urandom);
      do_write(a, d, 1'b0);
      check_outputs(f_writable(a) ? "R4" : "R5");
      do_read(f_writable(a) ? "R4" : "R5", a, 1'b0);
    end

    do_write(3'd3, 16'h00FF, 1'b0);
    do_read("R5", 3'd3, 1'b0);
    do_write(3'd2, 16'hFFFF, 1'b0);
    do_read("R5", 3'd2, 1'b0);

    do_write(3'd4, 16'h0F0F, 1'b0);
    cs_begin();
    for (int i = 7; i >= 0; i--) send_bit(wcmd(3'd4)[i], r, oe);
    for (int i = 15; i >= 6; i--) send_bit(1'b1 ^ i[0], r, oe);
    cs_end();
    check_outputs("R6");
    do_read("R6", 3'd4, 1'b0);

    do_write(3'd1, 16'h00A5, 1'b1);
    do_read("R7", 3'd7, 1'b1);
    do_write(3'd6, 16'h1357, 1'b1);
    do_read("R7", 3'd1, 1'b1);
    do_read("R7", 3'd6, 1'b1);
    cs_end();
    check_outputs("R7");

    xfer(8'hA0, 16'h003C, 1'b1, rd, bc, bd);
    check("R8", "oe in malformed write", 16'(bd), 16'd0);
    do_read("R8", 3'd4, 1'b1);
    xfer(8'h21, 16'h00C3, 1'b1, rd, bc, bd);
    check("R8", "oe in bad low bits", 16'(bd), 16'd0);
    xfer(8'hE0, 16'h0000, 1'b1, rd, bc, bd);
    check("R8", "oe in malformed read", 16'(bd), 16'd0);
    do_read("R8", 3'd4, 1'b1);
    cs_end();
    check_outputs("R8");

    do_write(3'd5, 16'hBEEF, 1'b0);
    cs_begin();
    send_run(31, 1'b1);
    send_run(1, 1'b0);
    cs_end();
    check_outputs("R10");
    cs_begin(); send_run(20, 1'b1); cs_end();
    cs_begin(); send_run(20, 1'b1); cs_end();
    check_outputs("R10");
    do_read("R10", 3'd5, 1'b0);

    do_write(3'd7, 16'h0033, 1'b0);
    cs_begin();
    send_run(32, 1'b1);
    model_reset();
    do_read("R9", 3'd5, 1'b1);
    do_read("R9", 3'd7, 1'b1);
    cs_end();
    check_outputs("R9");

    $display("[TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end
endmodule